// File: doc/BRIEF.md
# Threshold-Buffered Serial Word Receiver

This block turns a serial bit stream into parallel words and queues them for a host. Each bit is taken on a cycle where the sample strobe is high. A frame sync pulse marks where a word begins. The word length can be set to 8, 12, 16, 20, 24 or 32 bits. When the last bit of a word arrives, the word goes into a FIFO of 32-bit entries, stored right-justified. Words are normally taken most significant bit first. A 2-bit order field can instead make the first received bit the least significant one.

The host, or a DMA engine, watches a request output. That output is high while the FIFO holds at least a programmable number of words. Each read strobe pops one word into a registered read-data output. If a finished word meets a full FIFO, the word is dropped and a sticky overrun flag is raised. The host clears the flag by writing a one to its clear input.

Top module: `serial_rx_buffer`

## Requirements
- R1: After reset, `req` is 0, `overrun` is 0, `rd_data` is 0 and the FIFO is empty.
- R2: `cfg_wlen` selects the word length: 0=8, 1=12, 2=16, 3=20, 4=24, 5=32 bits, and codes 6 and 7 also give 32 bits. Each word is stored right-justified, with all bits above the word length at zero.
- R3: When `cfg_order` is any value other than 2'b01, the first bit received becomes bit N-1 of the stored word (most significant bit first).
- R4: When `cfg_order` equals 2'b01, the first bit received becomes bit 0 of the stored word (least significant bit first). This holds for every word length.
- R5: A bit is taken only in a cycle where `bit_en` is 1. A word enters the FIFO at the clock edge that samples its last bit. Cycles with `bit_en` at 0 add nothing to the word.
- R6: When `fsync` is 1, the bit counter restarts and any partial word is dropped. A bit sampled in that same cycle is the first bit of the new word.
- R7: `req` is 1 exactly when `cfg_thresh` is nonzero and the FIFO level is at least `cfg_thresh`. It follows each push or pop from the next cycle on, including falling as soon as the level drops below the threshold.
- R8: When `rd_en` is 1 and the FIFO is not empty, the oldest word is popped and appears on `rd_data` after that clock edge. Words come out in arrival order.
- R9: A read while the FIFO is empty sets `rd_data` to 0 and leaves the FIFO unchanged.
- R10: A word completed while the FIFO holds DEPTH entries is discarded, even if a read happens in the same cycle, and `overrun` is set and stays set.
- R11: A 1 on `overrun_clr` clears `overrun`. A new overrun in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Sample strobe for the serial input |
| ser_in | input | 1 | Serial data bit |
| fsync | input | 1 | Frame sync; restarts the word |
| cfg_wlen | input | 3 | Word length code |
| cfg_order | input | 2 | Bit order field; 2'b01 selects least significant bit first |
| cfg_thresh | input | LVL_W | FIFO level that raises the request; 0 disables it |
| rd_en | input | 1 | Host read strobe; pops one word |
| rd_data | output | 32 | Last word read, registered |
| req | output | 1 | Interrupt or DMA request |
| overrun_clr | input | 1 | Write-one-to-clear for the overrun flag |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The main function is checked with each of the six word lengths in both bit orders, using values whose top and bottom bits differ. A wrong length, a shift in the wrong direction or a missing reversal therefore gives a different word. A frame sync is sent in the middle of a word to show that the partial bits are dropped rather than joined to the next word. An order value of 2'b10 is also sent, to show that only 2'b01 reverses the bits. The FIFO is then filled to its depth plus one. This checks that the extra word is lost, that the stored words still come out in order, and that the request follows the threshold both upward and downward.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } rx_word_t;

    function automatic logic [5:0] wlen_bits(input logic [2:0] code);
        logic [5:0] n;
        case (code)
            3'd0:    n = 6'd8;
            3'd1:    n = 6'd12;
            3'd2:    n = 6'd16;
            3'd3:    n = 6'd20;
            3'd4:    n = 6'd24;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] bit_rev(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] low_mask(input logic [5:0] n);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) m[i] = (i < int'(n));
        return m;
    endfunction

endpackage

// File: rtl/serial_rx_shifter.sv
module serial_rx_shifter
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       ser_in,
    input  logic       fsync,
    input  logic [2:0] cfg_wlen,
    input  logic [1:0] cfg_order,
    output rx_word_t   word_out
);
    logic [WORD_W-1:0] shift_q, base_shift, next_shift;
    logic [5:0]        cnt_q, base_cnt, nbits;
    logic              last_bit;

    always_comb begin
        nbits      = wlen_bits(cfg_wlen);
        base_shift = fsync ? '0 : shift_q;
        base_cnt   = fsync ? '0 : cnt_q;
        next_shift = {base_shift[WORD_W-2:0], ser_in};
        last_bit   = bit_en && (base_cnt >= nbits - 6'd1);
        word_out.valid = last_bit;
        if (cfg_order == 2'b01)
            word_out.data = bit_rev(next_shift) >> (6'd32 - nbits);
        else
            word_out.data = next_shift & low_mask(nbits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (bit_en) begin
            if (last_bit) begin
                shift_q <= '0;
                cnt_q   <= '0;
            end else begin
                shift_q <= next_shift;
                cnt_q   <= base_cnt + 6'd1;
            end
        end else if (fsync) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q < 6'd32);

    assert_fsync_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (fsync && !bit_en) |=> (cnt_q == 6'd0));

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_word_t          push,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              dropped,
    output logic [LVL_W-1:0]  level
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push.valid && !full;
    assign do_pop  = pop && !empty;
    assign dropped = push.valid && full;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    assert_level_bound_R10: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    assert_full_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);

    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push.valid) |=> empty);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    input  logic             dropped,
    input  logic             ovr_clr,
    output logic             req,
    output logic             overrun
);
    assign req = (thresh != '0) && (level >= thresh);

    always_ff @(posedge clk) begin
        if (rst)          overrun <= 1'b0;
        else if (dropped) overrun <= 1'b1;
        else if (ovr_clr) overrun <= 1'b0;
    end

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);

    assert_set_prio_R11: assert property (@(posedge clk) disable iff (rst)
        dropped |=> overrun);

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              ser_in,
    input  logic              fsync,
    input  logic [2:0]        cfg_wlen,
    input  logic [1:0]        cfg_order,
    input  logic [LVL_W-1:0]  cfg_thresh,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              req,
    input  logic              overrun_clr,
    output logic              overrun
);
    rx_word_t          word;
    logic [WORD_W-1:0] head;
    logic              empty, full, dropped;
    logic [LVL_W-1:0]  level;

    serial_rx_shifter u_shift (
        .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in), .fsync(fsync),
        .cfg_wlen(cfg_wlen), .cfg_order(cfg_order), .word_out(word)
    );

    serial_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(word), .pop(rd_en), .head(head),
        .empty(empty), .full(full), .dropped(dropped), .level(level)
    );

    serial_rx_status #(.LVL_W(LVL_W)) u_stat (
        .clk(clk), .rst(rst), .level(level), .thresh(cfg_thresh),
        .dropped(dropped), .ovr_clr(overrun_clr), .req(req), .overrun(overrun)
    );

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= empty ? '0 : head;
    end

    assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> (rd_data == '0));

endmodule

// File: tb/serial_rx_buffer_tb.sv
module serial_rx_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 0, rst = 1;
    logic bit_en = 0, ser_in = 0, fsync = 0, rd_en = 0, overrun_clr = 0;
    logic [2:0] cfg_wlen = 0;
    logic [1:0] cfg_order = 0;
    logic [LVL_W-1:0] cfg_thresh = 0;
    logic [31:0] rd_data;
    logic req, overrun;

    int checks = 0, errors = 0;
    logic [31:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in), .fsync(fsync),
        .cfg_wlen(cfg_wlen), .cfg_order(cfg_order), .cfg_thresh(cfg_thresh),
        .rd_en(rd_en), .rd_data(rd_data), .req(req),
        .overrun_clr(overrun_clr), .overrun(overrun)
    );

    task automatic check(input string req_id, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req_id, act, exp);
        end
    endtask

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
            3'd3: return 20; 3'd4: return 24; default: return 32;
        endcase
    endfunction

    // driver: sends v with the current order, queues expected word if stored
    task automatic send_word(input logic [31:0] v, input bit sync, input bit expect_store);
        int n = len_of(cfg_wlen);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1;
            fsync  = sync && (i == 0);
            ser_in = (cfg_order == 2'b01) ? v[i] : v[n-1-i];
        end
        @(negedge clk);
        bit_en = 0; fsync = 0;
        if (expect_store) expq.push_back(n == 32 ? v : (v & ((32'd1 << n) - 1)));
    endtask

    // monitor side: read one word and compare against the scoreboard
    task automatic read_cmp(input string req_id);
        logic [31:0] e;
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
        e = (expq.size() > 0) ? expq.pop_front() : 32'd0;
        check(req_id, rd_data, e);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", {31'd0, req}, 0);
        check("R1", {31'd0, overrun}, 0);
        check("R1", rd_data, 0);

        // R2 R3 R4 all lengths both orders
        for (int c = 0; c < 8; c++) begin
            for (int o = 0; o < 2; o++) begin
                cfg_wlen = 3'(c);
                cfg_order = o ? 2'b01 : 2'b00;
                send_word(32'hF3C5_A961 ^ (32'(c) << 4), 0, 1);
                read_cmp(o ? "R4" : "R2_R3");
            end
        end

        // R3: order 2'b10 is not reversal
        cfg_wlen = 3'd0; cfg_order = 2'b10;
        send_word(32'h0000_0081 | 32'h40, 0, 1);
        read_cmp("R3");

        // R5: idle cycles between bits add nothing
        cfg_order = 2'b00;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); bit_en = 1; ser_in = (8'hB4 >> (7 - i)) & 1;
            @(negedge clk); bit_en = 0; ser_in = 1;
        end
        expq.push_back(32'hB4);
        read_cmp("R5");

        // R6: fsync mid-word drops partial bits
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); bit_en = 1; ser_in = 1;
        end
        @(negedge clk); bit_en = 0;
        send_word(32'h0000_005A, 1, 1);
        read_cmp("R6");

        // R9: empty read returns zero
        read_cmp("R9");

        // R7 threshold
        cfg_thresh = 4;
        for (int i = 0; i < 3; i++) send_word(32'h10 + 32'(i), 0, 1);
        check("R7", {31'd0, req}, 0);
        send_word(32'h13, 0, 1);
        check("R7", {31'd0, req}, 1);
        read_cmp("R8");
        check("R7", {31'd0, req}, 0);
        for (int i = 0; i < 3; i++) read_cmp("R8");

        // R10 overflow
        cfg_thresh = 0;
        for (int i = 0; i < DEPTH; i++) send_word(32'h40 + 32'(i), 0, 1);
        check("R10", {31'd0, overrun}, 0);
        check("R7", {31'd0, req}, 0);
        send_word(32'hEE, 0, 0);
        check("R10", {31'd0, overrun}, 1);
        for (int i = 0; i < DEPTH; i++) read_cmp("R10");
        read_cmp("R9");
        check("R10", {31'd0, overrun}, 1);

        // R11 clear
        @(negedge clk); overrun_clr = 1;
        @(negedge clk); overrun_clr = 0;
        check("R11", {31'd0, overrun}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule